// File: doc/BRIEF.md
# Crossbar Destination Arbiter with Switchable Priority Direction

This block sits at one destination port of a crossbar. It takes packets from nine sources, banks 0 to 7 and an I/O source at index 8, and sends them out one at a time on a single stream. Each source has its own small queue. When the arbiter is idle it takes a snapshot of every source that has a packet waiting and samples the direction pin at that moment. It then drains the snapshot one packet per source, in ascending order (lowest index first) or descending order (highest index first). Packets that arrive during the drain wait for the next snapshot.

A source can mark a packet as the first half of an atomic pair. Once that packet leaves, the arbiter locks onto that source. The next packet from the same source leaves next, and no other source is granted in between. The second half carries no new request of its own. It is simply the next entry in that source's queue. If it has not arrived yet, the arbiter waits with its output idle.

Both the input side and the output side are valid/ready streams. A source packet is accepted in a cycle where `src_valid[i]` and `src_ready[i]` are both high. `src_ready[i]` is low only while queue i is full. The output moves a packet in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold steady and no grant is issued. `grant` is a one-hot echo to the source whose packet moves in that cycle.

Top module: `xbar_dest_arb`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and every `src_ready` bit is 1. A reset in the middle of operation discards all queued and pending packets, so none of them ever appear at the output.
- R2: With `dir_asc`=1 at the snapshot, the sources in the snapshot are sent in ascending index order: source 0 first, source 8 last.
- R3: With `dir_asc`=0 at the snapshot, the order is descending: source 8 first, source 0 last.
- R4: The direction is sampled one cycle after the packets enter the queues, at the clock edge where the snapshot is taken. The value of `dir_asc` in the cycle the requests were presented has no effect on the order.
- R5: Every source in a snapshot sends exactly one packet. With `out_ready` held at 1, a snapshot of n sources and no atomic pair produces n packets in n consecutive cycles.
- R6: A packet with `src_atom[i]`=1 leaves with `out_atom`=1. The next packet to leave is the next queue entry of source i, with `out_atom`=0, even when other sources in the snapshot rank between them.
- R7: While the second half of an atomic pair has not yet arrived, `out_valid` stays 0 and no other source is granted.
- R8: A packet that enters while a snapshot is draining is sent only after every packet of that snapshot, whatever its priority.
- R9: Each source queue holds `Q_DEPTH` packets (2 by default). `src_ready[i]` is 0 while queue i is full, and a packet presented then is not accepted and never appears at the output.
- R10: While `out_valid`=1 and `out_ready`=0, `grant` is 0, and in the next cycle `out_valid` is still 1 with `out_data` unchanged.
- R11: `grant` is either zero or one-hot. It is nonzero only in a transfer cycle, and then bit i is set exactly when the packet comes from source i. Source i's packet is taken from `src_data[i*DATA_W +: DATA_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_asc | input | 1 | 1: ascending source priority, 0: descending; sampled at snapshot |
| src_valid | input | NUM_SRC | Per-source packet valid |
| src_ready | output | NUM_SRC | Per-source queue not full |
| src_atom | input | NUM_SRC | Per-source flag marking the first half of an atomic pair |
| src_data | input | NUM_SRC*DATA_W | Per-source packet payloads, source i in slice i |
| out_valid | output | 1 | Output packet valid |
| out_ready | input | 1 | Downstream accepts the output packet |
| out_data | output | DATA_W | Output packet payload |
| out_atom | output | 1 | Output packet opens an atomic pair |
| grant | output | NUM_SRC | One-hot index of the source whose packet moves this cycle |

## Verification
Two activities can land in the same cycle. One is an atomic first packet being granted while lower-ranked members of its snapshot are still pending. The other is new packets arriving while a snapshot drains. The bench provokes both with directed cases:
- an atomic pair from a mid-ranked source inside a wider snapshot;
- a high-priority arrival injected after the snapshot is taken.

It also runs seeded random snapshots. These mix in an atomic source, a direction that flips between the request cycle and the snapshot cycle, and random output back-pressure. Each case is judged by comparing the full output sequence, the atomic flags and the grants against an order computed from the snapshot mask and the sampled direction.

// File: rtl/xarb_pkg.sv
package xarb_pkg;
  localparam int XARB_SRC_DEF = 9;
  localparam int XARB_DW_DEF  = 16;
  localparam int XARB_QD_DEF  = 2;

  typedef enum logic {
    ORD_DESC = 1'b0,
    ORD_ASC  = 1'b1
  } ord_e;
endpackage

// File: rtl/xarb_srcq.sv
module xarb_srcq #(
  parameter int DW    = 16,
  parameter int DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [DW:0] wr_data,
  input  logic        rd_en,
  output logic [DW:0] rd_data,
  output logic        full,
  output logic        empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW:0]   mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_wr   = wr_en & ~full;
  assign do_rd   = rd_en & ~empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/xarb_pick.sv
module xarb_pick #(
  parameter int N = 9
) (
  input  logic [N-1:0] req,
  input  logic         asc,
  output logic [N-1:0] gnt
);
  logic [N-1:0] rev_in, low_a, low_d, rev_out;

  for (genvar g = 0; g < N; g++) begin : g_rev
    assign rev_in[g]  = req[N-1-g];
    assign rev_out[g] = low_d[N-1-g];
  end

  assign low_a = req & (~req + N'(1));
  assign low_d = rev_in & (~rev_in + N'(1));
  assign gnt   = asc ? low_a : rev_out;
endmodule

// File: rtl/xarb_outmux.sv
module xarb_outmux #(
  parameter int N  = 9,
  parameter int DW = 16
) (
  input  logic [N-1:0]    sel,
  input  logic [N*DW-1:0] data,
  input  logic [N-1:0]    atom,
  output logic [DW-1:0]   out_d,
  output logic            out_a
);
  always_comb begin
    out_d = '0;
    out_a = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) begin
        out_d = out_d | data[i*DW +: DW];
        out_a = out_a | atom[i];
      end
    end
  end
endmodule

// File: rtl/xbar_dest_arb.sv
module xbar_dest_arb
  import xarb_pkg::*;
#(
  parameter int NUM_SRC = XARB_SRC_DEF,
  parameter int DATA_W  = XARB_DW_DEF,
  parameter int Q_DEPTH = XARB_QD_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dir_asc,
  input  logic [NUM_SRC-1:0]        src_valid,
  output logic [NUM_SRC-1:0]        src_ready,
  input  logic [NUM_SRC-1:0]        src_atom,
  input  logic [NUM_SRC*DATA_W-1:0] src_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [DATA_W-1:0]         out_data,
  output logic                      out_atom,
  output logic [NUM_SRC-1:0]        grant
);
  logic [NUM_SRC-1:0]        q_full, q_empty, q_atom;
  logic [NUM_SRC*DATA_W-1:0] q_data;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_q
    logic [DATA_W:0] head_w;
    xarb_srcq #(.DW(DATA_W), .DEPTH(Q_DEPTH)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (src_valid[g]),
      .wr_data ({src_atom[g], src_data[g*DATA_W +: DATA_W]}),
      .rd_en   (grant[g]),
      .rd_data (head_w),
      .full    (q_full[g]),
      .empty   (q_empty[g])
    );
    assign q_atom[g]                   = head_w[DATA_W];
    assign q_data[g*DATA_W +: DATA_W]  = head_w[DATA_W-1:0];
  end

  assign src_ready = ~q_full;

  // snapshot and lock state
  logic [NUM_SRC-1:0] batch_mask, lock_oh, pick_oh, sel;
  ord_e               batch_ord;
  logic               locked;
  logic [DATA_W-1:0]  mux_data;
  logic               mux_atom, xfer;

  xarb_pick #(.N(NUM_SRC)) u_pick (
    .req (batch_mask),
    .asc (batch_ord == ORD_ASC),
    .gnt (pick_oh)
  );

  assign sel = locked ? lock_oh : pick_oh;

  xarb_outmux #(.N(NUM_SRC), .DW(DATA_W)) u_mux (
    .sel   (sel),
    .data  (q_data),
    .atom  (q_atom),
    .out_d (mux_data),
    .out_a (mux_atom)
  );

  assign out_valid = |(sel & ~q_empty);
  assign out_data  = mux_data;
  assign out_atom  = out_valid & ~locked & mux_atom;
  assign xfer      = out_valid & out_ready;
  assign grant     = xfer ? sel : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      batch_mask <= '0;
      batch_ord  <= ORD_ASC;
      locked     <= 1'b0;
      lock_oh    <= '0;
    end else if (!locked && batch_mask == '0) begin
      batch_mask <= ~q_empty;
      batch_ord  <= ord_e'(dir_asc);
    end else if (xfer) begin
      if (locked) begin
        locked <= 1'b0;
      end else begin
        batch_mask <= batch_mask & ~sel;
        if (mux_atom) begin
          locked  <= 1'b1;
          lock_oh <= sel;
        end
      end
    end
  end
endmodule

// File: rtl/xbar_dest_arb_chk.sv
module xbar_dest_arb_chk #(
  parameter int NUM_SRC = 9,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_atom,
  input logic [DATA_W-1:0]  out_data,
  input logic [NUM_SRC-1:0] grant
);
  // R1: reset leaves the output idle
  assert_rst_idle_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R11: at most one source granted
  assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R10: a stalled output holds its packet
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6: after an atomic first half, only the same source may be granted next
  assert_pair_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_atom) |=> (grant == '0 || grant == $past(grant)));
endmodule

bind xbar_dest_arb xbar_dest_arb_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_atom  (out_atom),
  .out_data  (out_data),
  .grant     (grant)
);

// File: tb/xbar_dest_arb_tb.sv
`timescale 1ns/1ps
module xbar_dest_arb_tb;
  localparam int NS = 9;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, dir_asc = 1'b1, out_ready = 1'b0;
  logic [NS-1:0]    src_valid = '0, src_atom = '0;
  logic [NS*DW-1:0] src_data = '0;
  logic [NS-1:0]    src_ready, grant;
  logic             out_valid, out_atom;
  logic [DW-1:0]    out_data;

  int n_chk = 0, n_err = 0, exp_n = 0;
  logic [15:0] exp_q [32];
  logic        exp_a [32];
  bit          done = 0;

  always #4 clk = ~clk;

  xbar_dest_arb u_dut (
    .clk(clk), .rst_n(rst_n), .dir_asc(dir_asc),
    .src_valid(src_valid), .src_ready(src_ready), .src_atom(src_atom),
    .src_data(src_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_atom(out_atom), .grant(grant)
  );

  function automatic logic [15:0] mk(int s, int part, int tag);
    return {4'(s), 4'(part), 8'(tag)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic clear_src();
    src_valid = '0;
    src_atom  = '0;
  endtask

  task automatic put(int s, logic [15:0] d, logic a);
    src_valid[s] = 1'b1;
    src_atom[s]  = a;
    src_data[s*DW +: DW] = d;
  endtask

  // expected order from snapshot mask, sampled direction and atomic source
  function automatic void build(logic [NS-1:0] m, bit asc, int atom_src, int tag);
    exp_n = 0;
    for (int k = 0; k < NS; k++) begin
      int i;
      i = asc ? k : NS - 1 - k;
      if (m[i]) begin
        exp_q[exp_n] = mk(i, 0, tag);
        exp_a[exp_n] = (i == atom_src);
        exp_n++;
        if (i == atom_src) begin
          exp_q[exp_n] = mk(i, 1, tag);
          exp_a[exp_n] = 1'b0;
          exp_n++;
        end
      end
    end
  endfunction

  // starts and ends just after a falling edge; the snapshot is taken in between
  task automatic send_batch(logic [NS-1:0] m, bit d0, bit d1, int atom_src, int tag, bit second);
    out_ready = 1'b0;
    dir_asc   = d0;
    for (int i = 0; i < NS; i++)
      if (m[i]) put(i, mk(i, 0, tag), i == atom_src);
    @(negedge clk);
    clear_src();
    dir_asc = d1;
    if (second && atom_src >= 0) put(atom_src, mk(atom_src, 1, tag), 1'b0);
    @(negedge clk);
    clear_src();
  endtask

  task automatic collect(int lo, int hi, int pct, string req, output int cycles);
    int got;
    bit stalled;
    logic [15:0] held;
    got = lo; stalled = 0; held = '0; cycles = 0;
    while (got <= hi && cycles < 200) begin
      out_ready = ($urandom_range(99) < pct);
      #1;
      if (stalled)
        chk(out_valid && out_data == held, "R10 stalled packet held",
            {out_valid, out_data}, {1'b1, held});
      stalled = 0;
      if (out_valid && out_ready) begin
        chk(out_data == exp_q[got], req, out_data, exp_q[got]);
        chk(out_atom == exp_a[got], "R6 out_atom flag", out_atom, exp_a[got]);
        chk(grant == (NS'(1) << out_data[15:12]), "R11 grant matches source",
            grant, NS'(1) << out_data[15:12]);
        got++;
      end else if (out_valid) begin
        chk(grant == '0, "R10 no grant while stalled", grant, 0);
        stalled = 1;
        held = out_data;
      end
      cycles++;
      @(negedge clk);
    end
    chk(got == hi + 1, req, got, hi + 1);
    out_ready = 1'b1;
    repeat (4) begin
      #1;
      chk(!out_valid, req, out_valid, 0);
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [NS-1:0] m;
    void'($urandom(32'h5eed));

    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R1 out_valid in reset", out_valid, 0);
    chk(src_ready == '1, "R1 src_ready in reset", src_ready, 9'h1ff);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
    @(negedge clk);

    // R2 ascending, R5 one per cycle
    m = 9'b1_0010_1001;
    build(m, 1, -1, 1);
    send_batch(m, 1, 1, -1, 1, 0);
    collect(0, exp_n - 1, 100, "R2 ascending order", cyc);
    chk(cyc == exp_n, "R5 one packet per cycle", cyc, exp_n);

    // R3 descending
    build(m, 0, -1, 2);
    send_batch(m, 0, 0, -1, 2, 0);
    collect(0, exp_n - 1, 100, "R3 descending order", cyc);
    chk(cyc == exp_n, "R5 one packet per cycle desc", cyc, exp_n);

    // R4: direction flips after the request cycle
    m = 9'b0_1000_0110;
    build(m, 0, -1, 3);
    send_batch(m, 1, 0, -1, 3, 0);
    collect(0, exp_n - 1, 100, "R4 direction sampled at snapshot", cyc);
    build(m, 1, -1, 4);
    send_batch(m, 0, 1, -1, 4, 0);
    collect(0, exp_n - 1, 100, "R4 direction sampled at snapshot", cyc);

    // R6: atomic pair inside a wider snapshot
    m = 9'b1_1000_0100;
    build(m, 0, 7, 5);
    send_batch(m, 0, 0, 7, 5, 1);
    collect(0, exp_n - 1, 100, "R6 pair back to back", cyc);
    m = 9'b0_0001_0001;
    build(m, 1, 0, 6);
    send_batch(m, 1, 1, 0, 6, 1);
    collect(0, exp_n - 1, 100, "R6 pair back to back", cyc);

    // R7: second half late, output waits
    m = 9'b0_0010_0010;
    build(m, 1, 1, 7);
    send_batch(m, 1, 1, 1, 7, 0);
    collect(0, 0, 100, "R7 lock waits for second half", cyc);
    put(1, mk(1, 1, 7), 1'b0);
    @(negedge clk);
    clear_src();
    collect(1, 2, 100, "R7 lock waits for second half", cyc);

    // R8: high-priority arrival during a drain
    m = 9'b0_0101_0000;
    build(m, 1, -1, 8);
    exp_q[2] = mk(0, 0, 8);
    exp_a[2] = 1'b0;
    send_batch(m, 1, 1, -1, 8, 0);
    put(0, mk(0, 0, 8), 1'b0);
    @(negedge clk);
    clear_src();
    collect(0, 2, 100, "R8 late arrival after snapshot", cyc);

    // R9: queue depth
    out_ready = 1'b0;
    put(2, mk(2, 0, 9), 1'b0);
    @(negedge clk);
    chk(src_ready[2] == 1'b1, "R9 ready with one entry", src_ready[2], 1);
    put(2, mk(2, 1, 9), 1'b0);
    @(negedge clk);
    chk(src_ready[2] == 1'b0, "R9 not ready when full", src_ready[2], 0);
    put(2, mk(2, 2, 9), 1'b0);
    @(negedge clk);
    clear_src();
    chk(src_ready[2] == 1'b0, "R9 still full", src_ready[2], 0);
    exp_q[0] = mk(2, 0, 9); exp_a[0] = 1'b0;
    exp_q[1] = mk(2, 1, 9); exp_a[1] = 1'b0;
    collect(0, 1, 100, "R9 overflow packet dropped", cyc);
    chk(src_ready == '1, "R9 ready after drain", src_ready, 9'h1ff);

    // R10: directed stall
    m = 9'b0_0100_1000;
    build(m, 1, -1, 10);
    send_batch(m, 1, 1, -1, 10, 0);
    repeat (3) begin
      #1;
      chk(out_valid && out_data == mk(3, 0, 10), "R10 hold under stall",
          {out_valid, out_data}, {1'b1, mk(3, 0, 10)});
      chk(grant == '0, "R10 no grant under stall", grant, 0);
      @(negedge clk);
    end
    collect(0, exp_n - 1, 100, "R10 order after stall", cyc);

    // R1: reset mid-run drops pending packets
    send_batch(9'b0_0000_0111, 1, 1, -1, 11, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    repeat (4) begin
      #1;
      chk(!out_valid, "R1 reset drops pending", out_valid, 0);
      @(negedge clk);
    end
    out_ready = 1'b0;

    // random snapshots with back-pressure
    for (int it = 0; it < 40; it++) begin
      int asrc;
      bit asc, d0;
      m    = NS'($urandom_range(1, 511));
      asc  = 1'($urandom_range(1));
      d0   = 1'($urandom_range(1));
      asrc = -1;
      if ($urandom_range(1) == 1) begin
        int start;
        start = $urandom_range(NS - 1);
        for (int k = 0; k < NS; k++)
          if (asrc < 0 && m[(start + k) % NS]) asrc = (start + k) % NS;
      end
      build(m, asc, asrc, 32 + it);
      send_batch(m, d0, asc, asrc, 32 + it, 1);
      collect(0, exp_n - 1, 70, asc ? "R2 random ascending" : "R3 random descending", cyc);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule